// File: doc/BRIEF.md
# I2C Start/Stop Condition Generator

This block sits between the serial shift path of a two-wire port and its open-drain pins. Software posts condition requests: start, repeated start, stop. It also writes a select bit that decides who owns the pins. With select low, the shift path's clock and data pull-down enables reach the pins unchanged. The block then only watches the bus and flags any start or stop that another master produces. With select high, an internal sequencer owns SCL and SDA and plays out each pending request as a series of timed phases. The start and stop interrupt flags then report that a generated condition has finished.

Software first sets the wanted request bit and then raises select. Each phase lasts a programmable number of ticks from a prescaler. Every request bit clears itself in hardware once its condition is complete. The pins keep the level of the last phase until the next sequence or until select drops. The block has no data stream: the register strobes, the tick and the pins are plain control signals with no handshake, and every strobe takes effect on the clock edge where it is seen.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, select is low, no request is pending, busy is low, both interrupt flags are 0, and the pins follow the shift-path enables.
- R2: While select is low, `scl_oe`/`sda_oe` equal `shift_scl_oe`/`shift_sda_oe`, and pending requests never start a sequence.
- R3: A sequence starts on the first clock edge at which select is already registered high, the sequencer is idle and a request is pending. Busy is high from the next cycle until the sequence completes. With several requests pending, start (`cfg_req[0]`) wins over repeated start (`cfg_req[1]`), which wins over stop (`cfg_req[2]`).
- R4: A start drives {scl_oe,sda_oe} = 01 and then 11. Each phase lasts `phase_ticks` ticks, and a value of 0 counts as 1.
- R5: A repeated start drives {scl_oe,sda_oe} = 10, 00, 01, 11 in that order.
- R6: A stop drives {scl_oe,sda_oe} = 01 and then 00. SDA is released while SCL is released only in a stop.
- R7: On completion, the request bit of that condition clears, busy drops, and the pins hold the last phase's pattern while select stays high.
- R8: With select high, `irq_start` sets when a start or repeated start completes and `irq_stop` sets when a stop completes. Conditions seen on the bus set neither flag.
- R9: With select low, the bus lines pass through a two-flop synchronizer. SDA falling while SCL is high sets `irq_start` two clock edges after the first synchronizer stage captures the change. SDA rising while SCL is high sets `irq_stop` with the same latency.
- R10: Each flag stays at 1 until its `irq_ack` or `flag_clr` bit (bit 0 start, bit 1 stop) is high at a clock edge. A set at the same edge wins over the clear.
- R11: If select drops during a sequence, the sequence freezes and the pins follow the shift path. When select rises again, the sequence resumes from the phase where it stopped.
- R12: Phase time advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_req | input | 3 | Request bits to set: 0 start, 1 repeated start, 2 stop |
| cfg_sel | input | 1 | Select value written with the strobe |
| flag_clr | input | 2 | Software clear of flags (0 start, 1 stop) |
| irq_ack | input | 2 | Interrupt acknowledge (0 start, 1 stop) |
| tick | input | 1 | Prescaled timing tick |
| phase_ticks | input | CNT_W | Ticks per phase |
| shift_scl_oe | input | 1 | Shift path SCL pull-down enable |
| shift_sda_oe | input | 1 | Shift path SDA pull-down enable |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| irq_start | output | 1 | Start interrupt flag |
| irq_stop | output | 1 | Stop interrupt flag |
| busy | output | 1 | Sequence in progress |
| req_pending | output | 3 | Pending request bits |
| sel_active | output | 1 | Registered select bit |

## Verification
On every cycle, the assertions check the following. No sequence starts with select low. A completed request is cleared. SDA is released under a released SCL only in a stop. A stalled sequence stays frozen. The flags stay set until cleared, and bus detection cannot touch them while the sequencer owns the pins. Only the bench scenarios can show the exact phase patterns and their durations under slow ticks, the request priority, and resumption after a stall. They also cover the synchronizer latency of detection and the race between a set and a clear.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;
  typedef enum logic [1:0] {
    K_START   = 2'd0,
    K_RESTART = 2'd1,
    K_STOP    = 2'd2
  } cond_e;

  localparam int NUM_REQ = 3;

  // pin pattern {scl_oe, sda_oe} for one phase of a condition
  function automatic logic [1:0] cond_pat(cond_e k, logic [1:0] s);
    logic [1:0] p;
    case (k)
      K_START:   p = (s == 2'd0) ? 2'b01 : 2'b11;
      K_RESTART: begin
        case (s)
          2'd0:    p = 2'b10;
          2'd1:    p = 2'b00;
          2'd2:    p = 2'b01;
          default: p = 2'b11;
        endcase
      end
      default:   p = (s == 2'd0) ? 2'b01 : 2'b00;
    endcase
    return p;
  endfunction

  function automatic logic [1:0] cond_last(cond_e k);
    return (k == K_RESTART) ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/i2c_cg_busmon.sv
module i2c_cg_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = STAGES;

  logic [TOP:0] scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[TOP-1:0], scl_in};
      sda_q <= {sda_q[TOP-1:0], sda_in};
    end
  end

  // compare newest synchronized sample with the one before
  assign start_det = scl_q[TOP] & scl_q[TOP-1] &  sda_q[TOP] & ~sda_q[TOP-1];
  assign stop_det  = scl_q[TOP] & scl_q[TOP-1] & ~sda_q[TOP] &  sda_q[TOP-1];
endmodule

// File: rtl/i2c_cg_flag.sv
module i2c_cg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o); // R10
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R10
endmodule

// File: rtl/i2c_cg_seq.sv
module i2c_cg_seq
  import i2c_cg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NUM_REQ-1:0] wr_req,
  input  logic             wr_sel,
  input  logic             tick,
  input  logic [CNT_W-1:0] phase_ticks,
  output logic             sel_q,
  output logic [NUM_REQ-1:0] req_q,
  output logic             busy_q,
  output logic [1:0]       pat_oe,
  output logic             done,
  output cond_e            kind_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       step_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       held_q;
  logic [CNT_W-1:0] lim;
  logic             phase_end;
  logic             advance;
  logic [NUM_REQ-1:0] clr_mask;
  cond_e            pick;

  assign lim       = (phase_ticks == '0) ? ONE : phase_ticks;
  assign phase_end = (cnt_q == lim - ONE);
  assign advance   = busy_q && sel_q && tick;
  assign done      = advance && phase_end && (step_q == cond_last(kind_q));
  assign clr_mask  = done ? (NUM_REQ'(1) << kind_q) : '0;

  always_comb begin
    if (req_q[0])      pick = K_START;
    else if (req_q[1]) pick = K_RESTART;
    else               pick = K_STOP;
  end

  assign pat_oe = busy_q ? cond_pat(kind_q, step_q) : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      req_q  <= '0;
      busy_q <= 1'b0;
      kind_q <= K_START;
      step_q <= '0;
      cnt_q  <= '0;
      held_q <= 2'b00;
    end else begin
      if (wr) sel_q <= wr_sel;
      req_q <= (req_q & ~clr_mask) | (wr ? wr_req : '0);
      if (!busy_q) begin
        if (sel_q && (req_q != '0)) begin
          busy_q <= 1'b1;
          kind_q <= pick;
          step_q <= '0;
          cnt_q  <= '0;
        end
      end else if (advance) begin
        if (phase_end) begin
          cnt_q <= '0;
          if (step_q == cond_last(kind_q)) begin
            busy_q <= 1'b0;
            held_q <= cond_pat(kind_q, step_q);
          end else begin
            step_q <= step_q + 2'd1;
          end
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  AST_NO_LAUNCH_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q && !busy_q |=> !busy_q); // R2
  AST_REQ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr |=> (req_q & $past(clr_mask)) == '0); // R7
  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done)); // R7
  AST_SDA_RELEASE_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $fell(pat_oe[0]) && !pat_oe[1] |-> kind_q == K_STOP); // R6
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !sel_q |=> $stable(step_q) && $stable(cnt_q)); // R11
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_req,
  input  logic             cfg_sel,
  input  logic [1:0]       flag_clr,
  input  logic [1:0]       irq_ack,
  input  logic             tick,
  input  logic [CNT_W-1:0] phase_ticks,
  input  logic             shift_scl_oe,
  input  logic             shift_sda_oe,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             irq_start,
  output logic             irq_stop,
  output logic             busy,
  output logic [2:0]       req_pending,
  output logic             sel_active
);
  logic       sel_q, busy_q, done, start_det, stop_det;
  logic [2:0] req_q;
  logic [1:0] pat_oe, set_v, clr_v, flag_v;
  cond_e      kind_q;

  i2c_cg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_req(cfg_req), .wr_sel(cfg_sel),
    .tick(tick), .phase_ticks(phase_ticks), .sel_q(sel_q), .req_q(req_q),
    .busy_q(busy_q), .pat_oe(pat_oe), .done(done), .kind_q(kind_q)
  );

  i2c_cg_busmon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det)
  );

  // flag source follows pin ownership
  assign set_v[0] = sel_q ? (done && kind_q != K_STOP) : start_det;
  assign set_v[1] = sel_q ? (done && kind_q == K_STOP) : stop_det;
  assign clr_v    = irq_ack | flag_clr;

  for (genvar g = 0; g < 2; g++) begin : g_flag
    i2c_cg_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[g]), .clr_i(clr_v[g]), .flag_o(flag_v[g])
    );
  end

  assign scl_oe      = sel_q ? pat_oe[1] : shift_scl_oe;
  assign sda_oe      = sel_q ? pat_oe[0] : shift_sda_oe;
  assign irq_start   = flag_v[0];
  assign irq_stop    = flag_v[1];
  assign busy        = busy_q;
  assign req_pending = req_q;
  assign sel_active  = sel_q;

  AST_SEL_MASKS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q && !irq_start && !(done && kind_q != K_STOP) |=> !irq_start); // R8
endmodule

// File: tb/sim_i2c_cond_gen.sv
`timescale 1ns/1ps
module sim_i2c_cond_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0, tick = 1, shift_scl_oe = 0, shift_sda_oe = 0;
  logic [2:0] cfg_req = 0;
  logic [1:0] flag_clr = 0, irq_ack = 0;
  logic [7:0] phase_ticks = 8'd1;
  logic tb_scl_pull = 0, tb_sda_pull = 0;
  logic scl_oe, sda_oe, irq_start, irq_stop, busy, sel_active;
  logic [2:0] req_pending;
  wire scl_in = ~scl_oe & ~tb_scl_pull;
  wire sda_in = ~sda_oe & ~tb_sda_pull;

  always #2.5 clk = ~clk;

  i2c_cond_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_req(cfg_req), .cfg_sel(cfg_sel),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .tick(tick), .phase_ticks(phase_ticks),
    .shift_scl_oe(shift_scl_oe), .shift_sda_oe(shift_sda_oe), .scl_in(scl_in),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_start(irq_start),
    .irq_stop(irq_stop), .busy(busy), .req_pending(req_pending), .sel_active(sel_active)
  );

  int checks = 0, fails = 0, tick_div = 1, tick_cnt = 0;
  string tag = "R1";
  bit finished = 0;

  // reference model state
  bit m_sel, m_busy, m_f0, m_f1, cur_scl = 1, cur_sda = 1;
  bit [2:0] m_req;
  bit [1:0] m_held;
  int m_kind, m_idx, m_cnt, lim;
  bit hs[3], hd[3];

  function automatic bit [1:0] mpat(int k, int i);
    if (k == 0) return (i == 0) ? 2'b01 : 2'b11;
    if (k == 1) begin
      if (i == 0) return 2'b10;
      if (i == 1) return 2'b00;
      if (i == 2) return 2'b01;
      return 2'b11;
    end
    return (i == 0) ? 2'b01 : 2'b00;
  endfunction
  function automatic int mlen(int k); return (k == 1) ? 4 : 2; endfunction

  always @(negedge clk) begin
    #1;
    cur_scl = scl_in;
    cur_sda = sda_in;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_busy = 0; m_f0 = 0; m_f1 = 0; m_req = 0; m_held = 0;
      m_kind = 0; m_idx = 0; m_cnt = 0;
      for (int i = 0; i < 3; i++) begin hs[i] = 1; hd[i] = 1; end
    end else begin
      bit ds, dp, fin, ss, sp;
      int fk;
      ds = hs[2] & hs[1] & hd[2] & !hd[1];
      dp = hs[2] & hs[1] & !hd[2] & hd[1];
      lim = (phase_ticks == 0) ? 1 : phase_ticks;
      fin = 0; fk = m_kind;
      if (m_busy) begin
        if (m_sel && tick) begin
          if (m_cnt == lim - 1) begin
            m_cnt = 0;
            if (m_idx == mlen(m_kind) - 1) begin
              fin = 1; m_busy = 0; m_held = mpat(m_kind, m_idx);
            end else m_idx++;
          end else m_cnt++;
        end
      end else if (m_sel && m_req != 0) begin
        m_busy = 1; m_idx = 0; m_cnt = 0;
        m_kind = m_req[0] ? 0 : (m_req[1] ? 1 : 2);
      end
      ss = m_sel ? (fin && fk != 2) : ds;
      sp = m_sel ? (fin && fk == 2) : dp;
      if (ss) m_f0 = 1; else if (irq_ack[0] | flag_clr[0]) m_f0 = 0;
      if (sp) m_f1 = 1; else if (irq_ack[1] | flag_clr[1]) m_f1 = 0;
      if (fin) m_req[fk] = 0;
      if (cfg_wr) begin m_req |= cfg_req; m_sel = cfg_sel; end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = cur_scl;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = cur_sda;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [1:0] p;
    p = m_busy ? mpat(m_kind, m_idx) : m_held;
    chk("scl_oe", scl_oe, m_sel ? p[1] : shift_scl_oe);
    chk("sda_oe", sda_oe, m_sel ? p[0] : shift_sda_oe);
    chk("irq_start", irq_start, m_f0);
    chk("irq_stop", irq_stop, m_f1);
    chk("busy", busy, m_busy);
    chk("req_pending", req_pending, m_req);
    chk("sel_active", sel_active, m_sel);
  endtask

  // advance one cycle: compare at negedge, then set the tick for the next edge
  task automatic step();
    @(negedge clk);
    compare();
    cfg_wr = 0; flag_clr = 0; irq_ack = 0;
    tick_cnt++;
    tick = (tick_cnt % tick_div) == 0;
  endtask
  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic wr(bit [2:0] rq, bit sl);
    step();
    cfg_wr = 1; cfg_req = rq; cfg_sel = sl;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; run(2);                       // reset state
    tag = "R2";                               // shifter passthrough, no launch
    shift_scl_oe = 1; run(2); shift_sda_oe = 1; run(2);
    shift_scl_oe = 0; shift_sda_oe = 0; run(3);
    wr(3'b001, 0); run(8);
    tag = "R9";                               // bus detection with select low
    tb_sda_pull = 1; run(6); tb_sda_pull = 0; run(6);
    tag = "R10"; step(); irq_ack = 2'b01; step(); flag_clr = 2'b10; run(3);
    tag = "R4"; wr(3'b000, 1); run(8);        // start pending, select now high
    tag = "R8"; tb_sda_pull = 1; run(5); tb_sda_pull = 0; run(5);
    tag = "R5"; wr(3'b010, 1); run(10);
    tag = "R6"; wr(3'b100, 1); run(8);
    tag = "R10"; step(); flag_clr = 2'b11; run(3);
    tag = "R3"; wr(3'b111, 1); run(25);       // priority start > restart > stop
    tag = "R12"; tick_div = 3; phase_ticks = 2; wr(3'b010, 1); run(40);
    tag = "R7"; wr(3'b100, 1); run(30);
    tag = "R11"; tick_div = 1; phase_ticks = 3; wr(3'b010, 1); run(4);
    wr(3'b000, 0); shift_sda_oe = 1; run(6); shift_sda_oe = 0;
    wr(3'b000, 1); run(20);
    tag = "R4"; phase_ticks = 0; wr(3'b001, 1); run(8);
    tag = "R10"; wr(3'b100, 1); run(2); irq_ack = 2'b10; run(6);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule